// File: doc/BRIEF.md
# Printable ASCII UART Stream Generator

This block repeatedly transmits the printable character range over an asynchronous serial line. A character sequencer walks through the codes from space (0x20) to tilde (0x7E) and then starts again at space. Control codes are never produced. A bit-rate tick generator divides the system clock down to the line rate, and an 8-bit transmitter shifts each character out.

The sequencer hands over a new code whenever the transmitter reports that it is empty. The hand-over itself clears the empty condition, so while the block is enabled the frames follow each other with one clock of idle between them. When enable is removed, the frame already on the line finishes normally. After that the line rests high, and the sequencer rewinds so that the next enabled run begins again at space.

Top module: `ascii_uart_stream`

## Requirements
- R1: Every character sent lies in 0x20..0x7E. Codes 0x00..0x1F and 0x7F never appear on the line.
- R2: Each character sent is the previous one plus one, except that 0x7E is followed by 0x20.
- R3: The first character after reset, and the first after enable returns high, is 0x20.
- R4: A frame is one low start bit, then eight data bits with bit 0 first, then one high stop bit. There is no parity bit.
- R5: Every bit lasts BIT_CLKS = round(CLK_HZ / BAUD) system clocks. The defaults are 12 MHz and 1200 baud, which gives 10000 clocks per bit with no rate error; any setting must keep the error under 1 percent.
- R6: `tx_empty` is high exactly when no frame is in progress. While enable is high, the start bit of the next frame appears one clock after `tx_empty` rises, and `tx_empty` drops at the same time.
- R7: During reset, and whenever the block is disabled with no frame in progress, `tx_line` is high and `tx_empty` is high.
- R8: If enable is deasserted in the middle of a frame, that frame completes in full and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows new characters to be started |
| tx_line | output | 1 | Serial transmit line, high when idle |
| tx_empty | output | 1 | High when the transmitter holds no frame |

## Verification
The hardest situation to reach from the ports is enable being removed at an arbitrary bit inside a frame, since the effect must show both as a complete frame and as silence afterwards. The stimulus drops enable at a random sample position inside the frame. It checks that the frame completes, watches the line for several bit times of idle, and then re-enables to confirm the restart at 0x20. Reset is also applied in the middle of a frame. A long continuous run passes through the 0x7E-to-0x20 wrap twice, with the bit period shortened through the parameters.

// File: rtl/ascii_uart_pkg.sv
// Package: shared constants, types and helper functions for the printable
// ASCII serial stream generator. Assumes 8-bit characters.
package ascii_uart_pkg;

    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] CODE_FIRST = 8'h20;
    localparam logic [CHAR_W-1:0] CODE_LAST  = 8'h7E;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    // Clocks per bit, rounded to the nearest integer.
    function automatic int bit_clocks(input int clk_hz, input int baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

    // Next printable code, wrapping from the last graphic code to space.
    function automatic logic [CHAR_W-1:0] next_code(input logic [CHAR_W-1:0] c);
        return (c == CODE_LAST) ? CODE_FIRST : c + 8'd1;
    endfunction

endpackage

// File: rtl/baud_tick_gen.sv
// Module: baud_tick_gen
// Produces a one-clock tick every DIV clocks while 'run' is high. Holds the
// count at zero while 'run' is low, so that the first tick of a frame comes
// exactly DIV clocks after the frame starts.
// Assumes DIV >= 2.
module baud_tick_gen #(
    parameter int DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick on the final count of each bit period.
    assign tick = run && (cnt_q == CNT_TOP);

    // Bit-period counter, cleared when idle or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);

    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/uart_tx_core.sv
// Module: uart_tx_core
// Asynchronous transmitter: one low start bit, DATA_W data bits with the
// least significant bit first, and one high stop bit. A 'load' is accepted
// only while 'empty' is high. Bit timing comes from an external tick.
module uart_tx_core
    import ascii_uart_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              bit_tick,
    output logic              busy,
    output logic              empty,
    output logic              txd
);
    localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_W - 1);

    tx_state_e         state_q;
    logic [DATA_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;

    assign busy  = (state_q != TX_IDLE);
    assign empty = (state_q == TX_IDLE);

    // Frame sequencing and line driver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shift_q <= '0;
            idx_q   <= '0;
            txd     <= 1'b1;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (load) begin
                        shift_q <= load_data;
                        txd     <= 1'b0;
                        state_q <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_tick) begin
                        txd     <= shift_q[0];
                        shift_q <= shift_q >> 1;
                        idx_q   <= '0;
                        state_q <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (bit_tick) begin
                        if (idx_q == LAST_BIT) begin
                            txd     <= 1'b1;
                            state_q <= TX_STOP;
                        end else begin
                            txd     <= shift_q[0];
                            shift_q <= shift_q >> 1;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                default: begin
                    if (bit_tick) begin
                        state_q <= TX_IDLE;
                    end
                end
            endcase
        end
    end

    p_load_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!txd && !empty));

    p_idle_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> txd);

    p_load_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> empty);

    p_stop_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_STOP) |-> txd);

endmodule

// File: rtl/ascii_sequencer.sv
// Module: ascii_sequencer
// Supplies printable codes in ascending order, one per transmitter empty
// condition while enabled. Rewinds to the first code whenever it is
// disabled, so that every enabled run starts at space.
module ascii_sequencer
    import ascii_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_empty,
    output logic              load,
    output logic [CHAR_W-1:0] code
);
    // Hand a code over as soon as the transmitter is empty.
    assign load = enable && tx_empty;

    // Code register: advance on each hand-over, rewind while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            code <= CODE_FIRST;
        end else if (load) begin
            code <= next_code(code);
        end
    end

    p_code_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (code >= CODE_FIRST && code <= CODE_LAST));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code == CODE_LAST) |=> (code == CODE_FIRST));

    p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (code == CODE_FIRST));

endmodule

// File: rtl/ascii_uart_stream.sv
// Module: ascii_uart_stream (top)
// Sends the printable character set, 0x20..0x7E, over a serial line without
// stopping, while enabled. Bit period = round(CLK_HZ / BAUD) clocks.
// Assumes the rounded rate is within 1 percent of BAUD.
module ascii_uart_stream
    import ascii_uart_pkg::*;
#(
    parameter int CLK_HZ = 12_000_000,
    parameter int BAUD   = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tx_line,
    output logic tx_empty
);
    localparam int BIT_CLKS = bit_clocks(CLK_HZ, BAUD);

    logic              busy;
    logic              tick;
    logic              load;
    logic [CHAR_W-1:0] code;

    baud_tick_gen #(.DIV(BIT_CLKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    ascii_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tx_empty (tx_empty),
        .load     (load),
        .code     (code)
    );

    uart_tx_core #(.DATA_W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (code),
        .bit_tick  (tick),
        .busy      (busy),
        .empty     (tx_empty),
        .txd       (tx_line)
    );

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && tx_empty) |=> (tx_empty && tx_line));

    p_frame_runs_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !tx_empty && !tick) |=> !tx_empty);

endmodule

// File: tb/test_ascii_uart_stream.sv
module test_ascii_uart_stream;
    localparam int CLK_PERIOD = 10;
    localparam int T_CLK_HZ   = 12000;
    localparam int T_BAUD     = 1200;
    localparam int DIV        = (T_CLK_HZ + T_BAUD / 2) / T_BAUD;
    localparam int FRAME      = 10 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic tx_line;
    logic tx_empty;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ascii_uart_stream #(.CLK_HZ(T_CLK_HZ), .BAUD(T_BAUD)) i_ascii_uart_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tx_line  (tx_line),
        .tx_empty (tx_empty)
    );

    function automatic logic [7:0] exp_next(input logic [7:0] c);
        return (c == 8'h7E) ? 8'h20 : c + 8'd1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Receive one frame, sampling at falling edges; optionally drop enable
    // at sample index drop_at inside the frame.
    task automatic recv(input int drop_at, output logic [7:0] b, output int waited);
        int s = 0;
        logic bv;
        b = '0;
        waited = 0;
        while (tx_line !== 1'b0 && waited < 4 * FRAME) begin
            @(negedge clk);
            waited++;
        end
        if (tx_line !== 1'b0) begin
            check(1'b0, "R6 no frame started", waited, 1);
            return;
        end
        for (int i = 0; i < DIV; i++) begin
            check(tx_line === 1'b0, "R4 start bit low", tx_line, 0);
            check(tx_empty === 1'b0, "R6 empty low in frame", tx_empty, 0);
            s++;
            if (s == drop_at) enable = 1'b0;
            @(negedge clk);
        end
        for (int k = 0; k < 8; k++) begin
            bv = tx_line;
            b[k] = bv;
            for (int i = 0; i < DIV; i++) begin
                if (i > 0) check(tx_line === bv, "R5 bit held for period", tx_line, bv);
                s++;
                if (s == drop_at) enable = 1'b0;
                @(negedge clk);
            end
        end
        for (int i = 0; i < DIV; i++) begin
            check(tx_line === 1'b1, "R4 stop bit high", tx_line, 1);
            s++;
            if (s == drop_at) enable = 1'b0;
            @(negedge clk);
        end
        check(tx_empty === 1'b1, "R6 empty after stop", tx_empty, 1);
    endtask

    task automatic check_char(input logic [7:0] got, input logic [7:0] exp, input string req);
        check(got >= 8'h20 && got <= 8'h7E, "R1 printable range", got, exp);
        check(got == exp, req, got, exp);
    endtask

    task automatic check_quiet(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            check(tx_line === 1'b1 && tx_empty === 1'b1, "R8 R7 idle after disable",
                  {tx_line, tx_empty}, 2'b11);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        int waited;
        void'($urandom(32'd4242));

        // Reset with enable high: line must rest.
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_line === 1'b1, "R7 line high in reset", tx_line, 1);
        check(tx_empty === 1'b1, "R7 empty in reset", tx_empty, 1);
        enable = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 5 + int'($urandom_range(0, 25)); i++) begin
            @(negedge clk);
            check(tx_line === 1'b1 && tx_empty === 1'b1, "R7 idle while disabled",
                  {tx_line, tx_empty}, 2'b11);
        end

        // Long continuous run covering the wrap twice.
        enable = 1'b1;
        exp = 8'h20;
        for (int n = 0; n < 200; n++) begin
            recv(-1, got, waited);
            if (n == 0) check_char(got, exp, "R3 first code 0x20");
            else begin
                check_char(got, exp, "R2 sequence step or wrap");
                check(waited == 1, "R6 back-to-back start", waited, 1);
            end
            exp = exp_next(got);
        end

        // Random mid-frame disables, then restart at space.
        for (int r = 0; r < 6; r++) begin
            recv(int'($urandom_range(1, FRAME - 1)), got, waited);
            check_char(got, exp, "R8 interrupted frame complete");
            check_quiet(3 * DIV);
            repeat (int'($urandom_range(0, 20))) @(negedge clk);
            enable = 1'b1;
            exp = 8'h20;
            for (int k = 0; k < 1 + int'($urandom_range(0, 3)); k++) begin
                recv(-1, got, waited);
                check_char(got, exp, (k == 0) ? "R3 restart at 0x20" : "R2 sequence step");
                exp = exp_next(got);
            end
        end

        // Reset in the middle of a frame.
        @(negedge clk);
        repeat (3 * DIV + int'($urandom_range(0, DIV))) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(tx_line === 1'b1, "R7 line high after mid-frame reset", tx_line, 1);
        check(tx_empty === 1'b1, "R7 empty after mid-frame reset", tx_empty, 1);
        rst_n = 1'b1;
        recv(-1, got, waited);
        check_char(got, 8'h20, "R3 first code after reset");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R6 actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule